// File: doc/BRIEF.md
# Write Buffer with Read Forwarding

This block sits between a processor's store path and a slower main-memory port. A store is accepted into a short queue, so the processor carries on without waiting for memory. The queue then writes its words to memory one at a time, in the order they were accepted. Each entry keeps its own address and data. A second store to an address that is already queued gets an entry of its own, so memory sees every write in program order.

A processor read can look up an address in the buffer in the same cycle. If any queued word matches, the youngest match supplies the data. If no queued word matches but the address falls in the held victim line, the victim supplies the word. Otherwise the read misses, and memory is known to be current for that address.

When the cache evicts a dirty line, the whole line is parked in a victim holder. While the cache controller reports a line fill in progress, the victim stays parked so the fill reaches memory first. Once the fill is finished, the victim words go out in ascending order and take precedence over queued words. An empty flag reports that nothing at all is pending, and can be used as a fence.

Top module: `wbuf_fwd`

## Requirements
- R1: While fewer than DEPTH words are queued, `wr_ready` is high, and a write presented with `wr_valid` is accepted in that cycle and becomes pending from the next cycle.
- R2: With DEPTH words queued, `wr_ready` is low and no write is accepted. It rises again in the cycle after a queued word is taken by memory.
- R3: Queued words go to memory in acceptance order, one per cycle in which `mem_valid` and `mem_ready` are both high. Writes to the same address are kept as separate entries and each one reaches memory.
- R4: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with the same `mem_addr` and `mem_data`.
- R5: `rd_hit` is high only when `rd_valid` is high and `rd_addr` equals the address of a queued word or of a word in the held victim line. On a queue match, `rd_data` is the data of the most recently accepted matching entry.
- R6: When no queued word matches, a read whose upper address bits (above the low log2(LINE_WORDS) bits) equal the held victim line returns the victim word selected by those low bits.
- R7: `ev_ready` is high exactly when no victim line is held. An accepted eviction captures `ev_line` and `ev_data`, where word i is `ev_data[i*DW +: DW]`.
- R8: A victim word is not offered to memory while `fill_pending` is high, unless that word was already being offered and not yet taken. With `fill_pending` low and a victim held, victim words are offered ahead of queued words, at addresses {line, 0} up to {line, LINE_WORDS-1} in that order. The holder frees after the last word is taken.
- R9: `buf_empty` is high exactly when no word is queued and no victim line is held.
- R10: After reset the block is empty: `buf_empty`, `wr_ready` and `ev_ready` are high and `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor store request |
| wr_ready | output | 1 | Queue can take a store |
| wr_addr | input | AW | Store word address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read lookup request |
| rd_addr | input | AW | Read word address |
| rd_hit | output | 1 | Read served by the buffer |
| rd_data | output | DW | Forwarded read data |
| ev_valid | input | 1 | Dirty line eviction offered |
| ev_ready | output | 1 | Victim holder free |
| ev_line | input | AW-log2(LINE_WORDS) | Line number of the evicted line |
| ev_data | input | LINE_WORDS*DW | Evicted line, word 0 in the low bits |
| fill_pending | input | 1 | A line fill from memory is in progress |
| mem_valid | output | 1 | Word write offered to memory |
| mem_ready | input | 1 | Memory takes the offered word |
| mem_addr | output | AW | Memory write word address |
| mem_data | output | DW | Memory write data |
| buf_empty | output | 1 | Nothing queued and no victim held |

## Verification
The assertions assume that the memory side only needs `mem_valid` and the payload to stay stable until `mem_ready` is seen. They also assume that `ev_valid` and `wr_valid` are requests the block may decline, with nothing required of them once declined. The stimulus changes every input at random on each falling edge, including `fill_pending` in the middle of a victim drain and `mem_ready` in the middle of an offer, because the block has to tolerate any such sequence. Addresses are drawn from a small range that overlaps the victim lines, so duplicate stores, multiple queue matches and victim matches all occur often.

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int LINE_WORDS = 4,
  localparam int OFFW = $clog2(LINE_WORDS),
  localparam int LW = AW - OFFW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_valid,
  input  logic [AW-1:0]            rd_addr,
  output logic                     rd_hit,
  output logic [DW-1:0]            rd_data,
  input  logic                     ev_valid,
  output logic                     ev_ready,
  input  logic [LW-1:0]            ev_line,
  input  logic [LINE_WORDS*DW-1:0] ev_data,
  input  logic                     fill_pending,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_data,
  output logic                     buf_empty
);
  // DEPTH >= 2, LINE_WORDS a power of two >= 2
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]   q_addr [DEPTH];
  logic [DW-1:0]   q_data [DEPTH];
  logic [PW-1:0]   head, tail;
  logic [CW-1:0]   cnt;
  logic            vic_valid;
  logic [LW-1:0]   vic_line;
  logic [DW-1:0]   vic_word [LINE_WORDS];
  logic [OFFW-1:0] vic_off;
  logic            sel_vic, sel_vic_q, busy_q;
  logic            push, pop, vbeat, ev_take;
  logic            q_hit, v_hit;
  logic [DW-1:0]   q_word;
  logic [PW-1:0]   idx;

  assign tail      = PW'((int'(head) + int'(cnt)) % DEPTH);
  assign wr_ready  = cnt != CW'(DEPTH);
  assign ev_ready  = !vic_valid;
  assign sel_vic   = busy_q ? sel_vic_q : (vic_valid && !fill_pending);
  assign mem_valid = sel_vic || (cnt != '0);
  assign mem_addr  = sel_vic ? {vic_line, vic_off} : q_addr[head];
  assign mem_data  = sel_vic ? vic_word[vic_off] : q_data[head];
  assign buf_empty = (cnt == '0) && !vic_valid;

  assign push    = wr_valid && wr_ready;
  assign pop     = mem_valid && mem_ready && !sel_vic;
  assign vbeat   = mem_valid && mem_ready && sel_vic;
  assign ev_take = ev_valid && ev_ready;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[tail] <= wr_addr;
      q_data[tail] <= wr_data;
    end
    if (ev_take) vic_line <= ev_line;
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_vic
    always_ff @(posedge clk)
      if (ev_take) vic_word[i] <= ev_data[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      cnt       <= '0;
      busy_q    <= 1'b0;
      sel_vic_q <= 1'b0;
      vic_valid <= 1'b0;
      vic_off   <= '0;
    end else begin
      if (pop) head <= PW'((int'(head) + 1) % DEPTH);
      cnt       <= cnt + CW'(push) - CW'(pop);
      busy_q    <= mem_valid && !mem_ready;
      sel_vic_q <= sel_vic;
      if (vbeat) begin
        vic_off <= vic_off + 1'b1;
        if (vic_off == OFFW'(LINE_WORDS - 1)) vic_valid <= 1'b0;
      end
      if (ev_take) begin
        vic_valid <= 1'b1;
        vic_off   <= '0;
      end
    end
  end

  always_comb begin
    q_hit  = 1'b0;
    q_word = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = PW'((int'(head) + k) % DEPTH);
      if (k < int'(cnt) && q_addr[idx] == rd_addr) begin
        q_hit  = 1'b1;
        q_word = q_data[idx];
      end
    end
  end

  assign v_hit   = vic_valid && (rd_addr[AW-1:OFFW] == vic_line);
  assign rd_hit  = rd_valid && (q_hit || v_hit);
  assign rd_data = q_hit ? q_word : vic_word[rd_addr[OFFW-1:0]];
endmodule

module wbuf_fwd_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_hit,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic          fill_pending,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          buf_empty,
  input logic [CW-1:0] cnt,
  input logic          sel_vic,
  input logic          busy_q
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> cnt <= $past(cnt));
  p_accept_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !buf_empty);
  p_mem_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  p_hit_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_hit);
  p_ev_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_ready && !buf_empty);
  p_fill_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vic && fill_pending |-> busy_q);
  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !mem_valid && wr_ready && ev_ready);
endmodule

bind wbuf_fwd wbuf_fwd_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_hit(rd_hit), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .fill_pending(fill_pending), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .buf_empty(buf_empty),
  .cnt(cnt), .sel_vic(sel_vic), .busy_q(busy_q)
);

// File: tb/wbuf_fwd_tb.sv
`timescale 1ns/1ps
module wbuf_fwd_tb;
  localparam int AW = 8, DW = 16, DEPTH = 4, LWD = 4, OFFW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_valid = 0, ev_valid = 0, fill_pending = 0, mem_ready = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [AW-OFFW-1:0] ev_line = 0;
  logic [LWD*DW-1:0] ev_data = 0;
  logic wr_ready, rd_hit, ev_ready, mem_valid, buf_empty;
  logic [DW-1:0] rd_data, mem_data;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  wbuf_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LINE_WORDS(LWD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_line(ev_line), .ev_data(ev_data), .fill_pending(fill_pending),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .buf_empty(buf_empty));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] mq_a[$];
  logic [DW-1:0] mq_d[$];
  bit m_vv, m_held, m_held_vic;
  logic [AW-OFFW-1:0] m_vline;
  logic [DW-1:0] m_vw [LWD];
  int m_voff;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq_a.delete(); mq_d.delete();
    m_vv = 0; m_held = 0; m_held_vic = 0; m_voff = 0;
  endtask

  task automatic step();
    bit e_wr, e_ev, e_sel, e_mv, e_hit, e_emp;
    logic [AW-1:0] e_ma;
    logic [DW-1:0] e_md, e_rd;
    e_wr  = mq_a.size() < DEPTH;
    e_ev  = !m_vv;
    e_sel = m_held ? m_held_vic : (m_vv && !fill_pending);
    e_mv  = e_sel || mq_a.size() > 0;
    e_ma  = e_sel ? {m_vline, 2'(m_voff)} : (mq_a.size() > 0 ? mq_a[0] : '0);
    e_md  = e_sel ? m_vw[m_voff] : (mq_a.size() > 0 ? mq_d[0] : '0);
    e_hit = 0; e_rd = '0;
    for (int i = mq_a.size() - 1; i >= 0; i--)
      if (!e_hit && mq_a[i] == rd_addr) begin e_hit = 1; e_rd = mq_d[i]; end
    if (!e_hit && m_vv && rd_addr[AW-1:OFFW] == m_vline) begin
      e_hit = 1; e_rd = m_vw[rd_addr[OFFW-1:0]];
    end
    e_hit = e_hit && rd_valid;
    e_emp = mq_a.size() == 0 && !m_vv;

    chk(wr_ready == e_wr, e_wr ? "R1" : "R2", "wr_ready", wr_ready, e_wr);
    chk(ev_ready == e_ev, "R7", "ev_ready", ev_ready, e_ev);
    chk(mem_valid == e_mv, "R3", "mem_valid", mem_valid, e_mv);
    if (e_mv) begin
      chk(mem_addr == e_ma, e_sel ? "R8" : "R3", "mem_addr", mem_addr, e_ma);
      chk(mem_data == e_md, e_sel ? "R8" : "R3", "mem_data", mem_data, e_md);
    end
    chk(rd_hit == e_hit, "R5", "rd_hit", rd_hit, e_hit);
    if (e_hit) chk(rd_data == e_rd, "R6", "rd_data", rd_data, e_rd);
    chk(buf_empty == e_emp, "R9", "buf_empty", buf_empty, e_emp);

    if (e_mv && mem_ready) begin
      if (e_sel) begin
        if (m_voff == LWD - 1) begin m_vv = 0; m_voff = 0; end
        else m_voff++;
      end else begin
        void'(mq_a.pop_front()); void'(mq_d.pop_front());
      end
    end
    m_held = e_mv && !mem_ready;
    m_held_vic = e_sel;
    if (wr_valid && e_wr) begin mq_a.push_back(wr_addr); mq_d.push_back(wr_data); end
    if (ev_valid && e_ev) begin
      m_vv = 1; m_voff = 0; m_vline = ev_line;
      for (int i = 0; i < LWD; i++) m_vw[i] = ev_data[i*DW +: DW];
    end
  endtask

  task automatic run(int n, int p_wr, int p_rdy, int p_ev, int p_fill);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      wr_valid = $urandom_range(99) < p_wr;
      wr_addr = AW'($urandom_range(15));
      wr_data = DW'($urandom);
      rd_valid = $urandom_range(99) < 70;
      rd_addr = AW'($urandom_range(17));
      ev_valid = $urandom_range(99) < p_ev;
      ev_line = (AW-OFFW)'($urandom_range(4));
      ev_data = {$urandom, $urandom};
      fill_pending = $urandom_range(99) < p_fill;
      mem_ready = $urandom_range(99) < p_rdy;
      #0.5;
      step();
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(buf_empty == 1, "R10", "buf_empty", buf_empty, 1);
    chk(wr_ready == 1, "R10", "wr_ready", wr_ready, 1);
    chk(ev_ready == 1, "R10", "ev_ready", ev_ready, 1);
    chk(mem_valid == 0, "R10", "mem_valid", mem_valid, 0);
    rst_n = 1;
    // R2: memory stalled, queue fills and write port closes
    run(8, 100, 0, 0, 0);
    chk(wr_ready == 0, "R2", "wr_ready when full", wr_ready, 0);
    // R3: same address written repeatedly, every entry drains
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      wr_valid = 1; wr_addr = 8'h05; wr_data = DW'(16'h100 + c);
      rd_valid = 1; rd_addr = 8'h05; ev_valid = 0; fill_pending = 0;
      mem_ready = c[0];
      #0.5; step();
    end
    // R8: victim parked during a long fill, then drained ahead of queue
    run(4, 0, 1, 100, 100);
    run(30, 50, 60, 0, 100);
    run(30, 50, 60, 0, 0);
    // mixed random traffic: R1 R4 R5 R6 R7 R9
    run(3000, 50, 50, 10, 40);
    run(3000, 80, 20, 20, 60);
    run(3000, 30, 90, 30, 20);
    run(200, 0, 100, 0, 0);
    chk(buf_empty == 1, "R9", "buf_empty after drain", buf_empty, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule